// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves a conditional relative branch. It takes the branch opcode, the four condition flags (negative, overflow, zero, carry), the address of the next instruction and a signed offset byte. It decides whether the branch is taken. For a taken branch it computes the target address. It also reports how many clock cycles the branch costs beyond the two-cycle base.

A branch costs one extra cycle when it is taken. It costs a second extra cycle when the target falls on a different 256-byte page from the next instruction. A small sequencer latches the result when `start` is sampled. It then holds `busy` for the extra cycles and pulses `done` once, so a surrounding core can stall for the correct number of clocks. The branch never alters the flags, because the block only reads them.

Top module: `br_unit`

## Requirements
- R1: A branch opcode has its low five bits equal to 10000b. Opcode bits [7:6] select the tested flag: 00 negative, 01 overflow, 10 carry, 11 zero. Opcode bit 5 gives the flag value that takes the branch (0 means branch when the flag is clear, 1 means branch when it is set).
- R2: For a taken branch, `new_pc` equals `next_pc` plus the sign-extended offset, modulo 2^ADDR_W, so offsets span -128 to +127.
- R3: When the branch is not taken, or when the opcode is not a branch opcode, `taken` is 0, `new_pc` equals `next_pc` and `extra_cyc` is 0.
- R4: A taken branch reports `extra_cyc` = 1 when the target lies on the same page as `next_pc`. It reports 2 when the address bits above the page-offset bits differ, including the case where the address wraps.
- R5: Results are registered on the clock edge that samples `start` while the block is idle. `busy` is then high for exactly `extra_cyc` cycles, after which `done` is high for one cycle. When `extra_cyc` is 0, `done` is high in the first cycle and `busy` stays low.
- R6: `start` is ignored while `busy` is high. The outputs and the `done` timing of the branch in progress are unchanged.
- R7: After reset, `taken`, `new_pc`, `extra_cyc`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to resolve the branch on the current inputs |
| opcode | input | 8 | Instruction opcode |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| next_pc | input | ADDR_W | Address of the instruction after the branch |
| offset | input | OFS_W | Signed branch displacement |
| taken | output | 1 | Branch taken (registered) |
| new_pc | output | ADDR_W | Next program counter (registered) |
| extra_cyc | output | 2 | Extra cycles beyond the base cost (registered) |
| busy | output | 1 | High while the extra cycles run |
| done | output | 1 | One-cycle pulse when the branch completes |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit offset and 8 page-offset bits. These values put all 256 offsets and every page relation within reach with a handful of addresses. This includes a backward step of one byte across a page boundary, the extremes +127 and -128, and a target that wraps from the top of the address space to page zero. All eight branch opcodes are run with their flag both set and clear, so both polarities of every condition are covered. A non-branch opcode and a start pulse arriving during a busy window are also exercised.

// File: rtl/br_pkg.sv
package br_pkg;
  // Low five opcode bits shared by every conditional branch
  localparam logic [4:0] BR_LOW_PATTERN = 5'b10000;

  typedef enum logic [1:0] {
    SEL_NEG  = 2'b00,
    SEL_OVF  = 2'b01,
    SEL_CARRY = 2'b10,
    SEL_ZERO = 2'b11
  } flag_sel_e;

  typedef struct packed {
    logic       is_branch;
    logic       taken;
  } cond_res_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       flag_n,
  input  logic       flag_v,
  input  logic       flag_z,
  input  logic       flag_c,
  output cond_res_t  res
);
  flag_sel_e sel;
  logic      want;
  logic      flag_val;

  always_comb begin
    sel  = flag_sel_e'(opcode[7:6]);
    want = opcode[5];
    unique case (sel)
      SEL_NEG:   flag_val = flag_n;
      SEL_OVF:   flag_val = flag_v;
      SEL_CARRY: flag_val = flag_c;
      default:   flag_val = flag_z;
    endcase
    res.is_branch = (opcode[4:0] == BR_LOW_PATTERN);
    res.taken     = res.is_branch && (flag_val == want);
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] target,
  output logic              page_cross
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext    = {{EXT_W{offset[OFS_W-1]}}, offset};
    target     = base_pc + ofs_ext;
    page_cross = (target[ADDR_W-1:PAGE_W] != base_pc[ADDR_W-1:PAGE_W]);
  end
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [OFS_W-1:0]  offset,
  output logic              taken,
  output logic [ADDR_W-1:0] new_pc,
  output logic [1:0]        extra_cyc,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = 2;

  cond_res_t         cres;
  logic [ADDR_W-1:0] tgt;
  logic              xpage;
  logic [ADDR_W-1:0] pc_next_c;
  logic [CNT_W-1:0]  extra_c;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept;

  br_cond_eval u_cond (
    .opcode (opcode),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .res    (cres)
  );

  br_target_calc #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .PAGE_W (PAGE_W)
  ) u_tgt (
    .base_pc    (next_pc),
    .offset     (offset),
    .target     (tgt),
    .page_cross (xpage)
  );

  always_comb begin
    accept    = start && !busy;
    pc_next_c = cres.taken ? tgt : next_pc;
    if (!cres.taken)   extra_c = 2'd0;
    else if (xpage)    extra_c = 2'd2;
    else               extra_c = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      new_pc    <= '0;
      extra_cyc <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cnt_q     <= '0;
    end else if (accept) begin
      taken     <= cres.taken;
      new_pc    <= pc_next_c;
      extra_cyc <= extra_c;
      cnt_q     <= extra_c;
      busy      <= (extra_c != 0);
      done      <= (extra_c == 0);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == 1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              taken,
  input logic [ADDR_W-1:0] new_pc,
  input logic [1:0]        extra_cyc,
  input logic              busy,
  input logic              done
);
  a_r3_idle_costs_nothing: assert property (@(posedge clk) disable iff (rst)
    !taken |-> extra_cyc == 2'd0);

  a_r4_taken_costs_extra: assert property (@(posedge clk) disable iff (rst)
    taken |-> (extra_cyc == 2'd1 || extra_cyc == 2'd2));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done || $past(start));

  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r5_busy_end_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(taken) && $stable(new_pc) && $stable(extra_cyc)));
endmodule

bind br_unit br_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .taken     (taken),
  .new_pc    (new_pc),
  .extra_cyc (extra_cyc),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_br_unit.sv
module test_br_unit;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        opcode = 8'hEA;
  logic              flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
  logic [ADDR_W-1:0] next_pc = '0;
  logic [OFS_W-1:0]  offset = '0;
  logic              taken;
  logic [ADDR_W-1:0] new_pc;
  logic [1:0]        extra_cyc;
  logic              busy;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  br_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(8)) i_br_unit (
    .clk (clk), .rst (rst), .start (start), .opcode (opcode),
    .flag_n (flag_n), .flag_v (flag_v), .flag_z (flag_z), .flag_c (flag_c),
    .next_pc (next_pc), .offset (offset), .taken (taken), .new_pc (new_pc),
    .extra_cyc (extra_cyc), .busy (busy), .done (done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference decision from R1: low bits 10000b, [7:6] selects N/V/C/Z, bit5 = wanted value
  function automatic logic ref_taken(input logic [7:0] op, input logic [3:0] nvzc);
    logic f;
    if (op[4:0] != 5'b10000) return 1'b0;
    case (op[7:6])
      2'b00: f = nvzc[3];
      2'b01: f = nvzc[2];
      2'b10: f = nvzc[0];
      default: f = nvzc[1];
    endcase
    return f == op[5];
  endfunction

  // Apply one branch and follow it to done; checks R2..R5
  task automatic run_branch(input string tag, input logic [7:0] op, input logic [3:0] nvzc,
                            input logic [15:0] pc, input logic [7:0] ofs,
                            input logic exp_t, input logic [15:0] exp_pc, input int exp_x);
    @(negedge clk);
    opcode = op; {flag_n, flag_v, flag_z, flag_c} = nvzc;
    next_pc = pc; offset = ofs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 taken"}, taken, exp_t);
    check({tag, " R2/R3 new_pc"}, new_pc, exp_pc);
    check({tag, " R4 extra_cyc"}, extra_cyc, exp_x);
    for (int i = 0; i < exp_x; i++) begin
      check({tag, " R5 busy"}, {busy, done}, 2'b10);
      @(negedge clk);
    end
    check({tag, " R5 done"}, {busy, done}, 2'b01);
    @(negedge clk);
    check({tag, " R5 done pulse ends"}, done, 1'b0);
  endtask

  task automatic t_reset();
    check("R7 taken", taken, 0);
    check("R7 new_pc", new_pc, 0);
    check("R7 extra_cyc", extra_cyc, 0);
    check("R7 busy/done", {busy, done}, 0);
  endtask

  task automatic t_all_conditions();
    logic [7:0] ops[8] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 2; f++) begin
        logic [3:0] nvzc;
        logic       t;
        nvzc = f[0] ? 4'hF : 4'h0;
        t = ref_taken(ops[k], nvzc);
        run_branch("R1 cond", ops[k], nvzc, 16'h1234, 8'h10, t,
                   t ? 16'h1244 : 16'h1234, t ? 1 : 0);
      end
    end
    // single flag isolation: only Z set, BEQ taken, BMI not
    run_branch("R1 zero only", 8'hF0, 4'b0010, 16'h2000, 8'h05, 1'b1, 16'h2005, 1);
    run_branch("R1 neg clear", 8'h30, 4'b0010, 16'h2000, 8'h05, 1'b0, 16'h2000, 0);
  endtask

  task automatic t_page_cases();
    run_branch("R4 fwd max same page", 8'h90, 4'h0, 16'h1200, 8'h7F, 1'b1, 16'h127F, 1);
    run_branch("R4 fwd cross", 8'h90, 4'h0, 16'h12F0, 8'h7F, 1'b1, 16'h136F, 2);
    run_branch("R2 back min cross", 8'hB0, 4'h1, 16'h1200, 8'h80, 1'b1, 16'h1180, 2);
    run_branch("R2 back one cross", 8'hB0, 4'h1, 16'h1200, 8'hFF, 1'b1, 16'h11FF, 2);
    run_branch("R2 back same page", 8'hD0, 4'h0, 16'h12FF, 8'hFE, 1'b1, 16'h12FD, 1);
    run_branch("R4 wrap top", 8'h10, 4'h0, 16'hFFF0, 8'h20, 1'b1, 16'h0010, 2);
    run_branch("R3 untaken far ofs", 8'h10, 4'h8, 16'h12F0, 8'h7F, 1'b0, 16'h12F0, 0);
  endtask

  task automatic t_non_branch();
    run_branch("R3 non-branch 4C", 8'h4C, 4'hF, 16'h3456, 8'h22, 1'b0, 16'h3456, 0);
    run_branch("R3 non-branch 11", 8'h11, 4'h0, 16'h3456, 8'h22, 1'b0, 16'h3456, 0);
  endtask

  task automatic t_start_while_busy();
    @(negedge clk);
    opcode = 8'h90; {flag_n, flag_v, flag_z, flag_c} = 4'h0;
    next_pc = 16'h12F0; offset = 8'h7F; start = 1'b1;
    @(negedge clk);
    check("R6 first busy", busy, 1);
    opcode = 8'hF0; {flag_n, flag_v, flag_z, flag_c} = 4'h0;
    next_pc = 16'h5555; offset = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 pc held", new_pc, 16'h136F);
    check("R6 extra held", extra_cyc, 2);
    check("R6 still busy", {busy, done}, 2'b10);
    @(negedge clk);
    check("R6 done on time", {busy, done}, 2'b01);
    check("R6 taken held", taken, 1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_conditions();
    t_page_cases();
    t_non_branch();
    t_start_while_busy();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule